// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an asynchronous DRAM alive. It brings the memory up after reset and then refreshes it at a steady rate. It uses the refresh mode in which the memory supplies the row from its own internal counter, so no address is driven.

After reset the block first keeps RAS and CAS idle for a fixed settling pause. It then runs a fixed number of warm-up refresh cycles on its own, and only then raises `ready`. From that point it owns the bus only on request. An interval timer adds one unit of refresh debt per period. While debt is outstanding and no refresh is in flight, it raises `ref_req`. The access controller answers with `ref_gnt` once it has released RAS, CAS and W. Each grant buys exactly one refresh cycle. If grants arrive late, the debt grows. A held grant drains it with refreshes issued one after another. `overdue` reports when the debt exceeds a configurable limit.

Every duration is a parameter in nanoseconds or microseconds. Cycle counts are derived from the clock frequency in MHz by rounding up, with a floor of one cycle.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, `ras_n`, `cas_n` and `we_n` are 1, and `bus_own`, `ready`, `ref_req` and `overdue` are 0.
- R2: For PAUSE_US*CLK_MHZ cycles after reset is released, RAS and CAS stay high. The first CAS fall is seen PAUSE_US*CLK_MHZ+1 cycles after release.
- R3: After the pause, exactly WARM_CYC (default 8) refresh cycles run without any grant, each 1+CSR+RAS+RP cycles apart. `ready` then rises and stays high until the next reset.
- R4: Each refresh lowers CAS while RAS is high, CSR cycles before RAS falls. CAS is held low for CHR cycles after the RAS fall and then returns high. RAS stays low RAS cycles, then high RP cycles before the bus is released. CSR, CHR, RAS and RP are the rounded-up cycle counts of TCSR_NS, TCHR_NS, TRAS_NS and TRP_NS; CHR is capped at RAS.
- R5: `we_n` stays high, and `bus_own` is high in every cycle in which RAS or CAS is low.
- R6: Once ready, one unit of debt is added every REFI_NS period, the first REFI cycles after `ready` rises. `ref_req` is high exactly while ready, debt is nonzero and no refresh is in flight.
- R7: `ref_gnt` sampled high while `ref_req` is high starts a refresh, with CAS falling one cycle later, and each finished refresh removes one unit of debt. `ref_gnt` has no effect while `ref_req` is low, including before `ready`.
- R8: With the grant held, outstanding debt drains through refreshes issued one after another, RAS falls 1+CSR+RAS+RP cycles apart, until `ref_req` falls.
- R9: `overdue` is high exactly when the debt exceeds MAX_PEND.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Access controller hands the bus over for one refresh |
| ref_req | output | 1 | Refresh debt outstanding, bus wanted |
| ready | output | 1 | Pause and warm-up finished; memory usable |
| overdue | output | 1 | Debt above MAX_PEND |
| bus_own | output | 1 | Block is driving RAS, CAS and W |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high for refresh |

## Verification
Some properties are checked on every cycle:
- CAS leads every RAS fall and only falls while RAS is high.
- W stays high.
- Bus ownership covers every strobe.
- The strobes stay quiet during the pause.
- `ready` never drops, and exactly the warm-up count of RAS falls precede it.
- Requests occur only once ready, and every ready-time refresh follows a sampled request and grant.

Other behaviour only the directed scenarios can show:
- The exact strobe widths and the pause length.
- The interval spacing and the point at which the debt limit is crossed.
- The spacing of the draining burst.
- That a grant given before `ready` or without a request changes nothing.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_WARM  = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    ENG_IDLE   = 2'd0,
    ENG_SETUP  = 2'd1,
    ENG_STROBE = 2'd2,
    ENG_PRECH  = 2'd3
  } eng_t;

  // Duration in ns -> clock cycles, rounded up, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  // Duration in us -> clock cycles.
  function automatic int unsigned us_to_cyc(input int unsigned us, input int unsigned mhz);
    int unsigned c;
    c = us * mhz;
    return (c < 1) ? 1 : c;
  endfunction

  // Counter width able to hold 0 .. n-1.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned min2(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/rfs_timebase.sv
module rfs_timebase
  import rfs_pkg::*;
#(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);
  localparam int unsigned W = cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign hit = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (!run) cnt <= '0;
    else if (hit)  cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfs_cbr_engine.sv
module rfs_cbr_engine
  import rfs_pkg::*;
#(
  parameter int unsigned CSR_CYC = 1,
  parameter int unsigned CHR_CYC = 1,
  parameter int unsigned RAS_CYC = 3,
  parameter int unsigned RP_CYC  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic done,
  output logic own,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int unsigned LONGEST = max2(max2(CSR_CYC, RAS_CYC), max2(RP_CYC, CHR_CYC + 1));
  localparam int unsigned CW = cnt_width(LONGEST);
  localparam logic [CW-1:0] CSR_LAST = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] RAS_LAST = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] RP_LAST  = CW'(RP_CYC - 1);
  localparam logic [CW-1:0] CHR_END  = CW'(CHR_CYC);

  eng_t         state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ENG_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ENG_IDLE: begin
          cnt <= '0;
          if (start) state <= ENG_SETUP;
        end
        ENG_SETUP: begin
          if (cnt == CSR_LAST) begin
            state <= ENG_STROBE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ENG_STROBE: begin
          if (cnt == RAS_LAST) begin
            state <= ENG_PRECH;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ENG_PRECH: begin
          if (cnt == RP_LAST) begin
            state <= ENG_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          state <= ENG_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign idle  = (state == ENG_IDLE);
  assign own   = (state != ENG_IDLE);
  assign done  = (state == ENG_PRECH) && (cnt == RP_LAST);
  assign ras_n = !(state == ENG_STROBE);
  assign cas_n = !((state == ENG_SETUP) || ((state == ENG_STROBE) && (cnt < CHR_END)));
  assign we_n  = 1'b1;
endmodule

// File: rtl/rfs_debt_ctr.sv
module rfs_debt_ctr
  import rfs_pkg::*;
#(
  parameter int unsigned PEND_W   = 4,
  parameter int unsigned MAX_PEND = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nonzero,
  output logic over
);
  localparam logic [PEND_W-1:0] FULL  = '1;
  localparam logic [PEND_W-1:0] LIMIT = PEND_W'(MAX_PEND);

  logic [PEND_W-1:0] pending;

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= '0;
    else begin
      case ({inc, dec})
        2'b10:   if (pending != FULL) pending <= pending + 1'b1;
        2'b01:   if (pending != '0)   pending <= pending - 1'b1;
        default: pending <= pending;
      endcase
    end
  end

  assign nonzero = (pending != '0);
  assign over    = (pending > LIMIT);
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import rfs_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 100,
  parameter int unsigned PAUSE_US = 200,
  parameter int unsigned REFI_NS  = 15600,
  parameter int unsigned TRAS_NS  = 50,
  parameter int unsigned TRP_NS   = 50,
  parameter int unsigned TCSR_NS  = 10,
  parameter int unsigned TCHR_NS  = 15,
  parameter int unsigned WARM_CYC = 8,
  parameter int unsigned MAX_PEND = 4,
  parameter int unsigned PEND_W   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ready,
  output logic overdue,
  output logic bus_own,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int unsigned PAUSE_CYC = us_to_cyc(PAUSE_US, CLK_MHZ);
  localparam int unsigned REFI_CYC  = ns_to_cyc(REFI_NS, CLK_MHZ);
  localparam int unsigned RAS_CYC   = ns_to_cyc(TRAS_NS, CLK_MHZ);
  localparam int unsigned RP_CYC    = ns_to_cyc(TRP_NS, CLK_MHZ);
  localparam int unsigned CSR_CYC   = ns_to_cyc(TCSR_NS, CLK_MHZ);
  localparam int unsigned CHR_CYC   = min2(ns_to_cyc(TCHR_NS, CLK_MHZ), RAS_CYC);
  localparam int unsigned WW        = cnt_width(WARM_CYC);
  localparam logic [WW-1:0] WARM_LAST = WW'(WARM_CYC - 1);

  phase_t        phase;
  logic [WW-1:0] warm_cnt;

  // Named internal events
  logic in_pause;
  logic in_warm;
  logic in_run;
  logic pause_hit;
  logic refi_tick;
  logic eng_idle;
  logic eng_done;
  logic eng_start;
  logic debt_nz;
  logic debt_over;
  logic run_done;

  assign in_pause = (phase == PH_PAUSE);
  assign in_warm  = (phase == PH_WARM);
  assign in_run   = (phase == PH_RUN);

  rfs_timebase #(.LIMIT(PAUSE_CYC)) i_pause_tmr (
    .clk(clk), .rst_n(rst_n), .run(in_pause), .hit(pause_hit)
  );

  rfs_timebase #(.LIMIT(REFI_CYC)) i_refi_tmr (
    .clk(clk), .rst_n(rst_n), .run(in_run), .hit(refi_tick)
  );

  assign ref_req   = in_run && debt_nz && eng_idle;
  assign eng_start = (in_warm && eng_idle) || (ref_req && ref_gnt);
  assign run_done  = in_run && eng_done;

  rfs_cbr_engine #(
    .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
  ) i_engine (
    .clk(clk), .rst_n(rst_n), .start(eng_start),
    .idle(eng_idle), .done(eng_done), .own(bus_own),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  rfs_debt_ctr #(.PEND_W(PEND_W), .MAX_PEND(MAX_PEND)) i_debt (
    .clk(clk), .rst_n(rst_n), .inc(refi_tick), .dec(run_done),
    .nonzero(debt_nz), .over(debt_over)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_PAUSE;
      warm_cnt <= '0;
    end else begin
      case (phase)
        PH_PAUSE: if (pause_hit) phase <= PH_WARM;
        PH_WARM: begin
          if (eng_done) begin
            if (warm_cnt == WARM_LAST) phase <= PH_RUN;
            else warm_cnt <= warm_cnt + 1'b1;
          end
        end
        PH_RUN:  phase <= PH_RUN;
        default: phase <= PH_PAUSE;
      endcase
    end
  end

  assign ready   = in_run;
  assign overdue = debt_over;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int unsigned WARM_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic bus_own,
  input logic ready,
  input logic ref_req,
  input logic ref_gnt,
  input logic overdue,
  input logic in_pause
);
  logic [7:0] warm_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) warm_seen <= '0;
    else if ($fell(ras_n) && !ready && warm_seen != 8'hFF) warm_seen <= warm_seen + 1'b1;
  end

  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_pause |-> (ras_n && cas_n)); // R2
  AST_WARM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (warm_seen == 8'(WARM_CYC))); // R3
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R3
  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !cas_n); // R4
  AST_CAS_FALLS_RAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ras_n); // R4
  AST_WE_HIGH_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> (we_n && bus_own)); // R5
  AST_REQ_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> ready); // R6
  AST_GRANT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $fell(cas_n)) |-> $past(ref_req && ref_gnt)); // R7
  AST_OVERDUE_DEBT: assert property (@(posedge clk) disable iff (!rst_n)
    overdue |-> (ref_req || bus_own)); // R9
endmodule

bind dram_refresh_sched dram_refresh_sched_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .bus_own(bus_own), .ready(ready), .ref_req(ref_req), .ref_gnt(ref_gnt),
  .overdue(overdue), .in_pause(in_pause)
);

// File: tb/test_dram_refresh_sched.sv
`timescale 1ns/1ps
module test_dram_refresh_sched;
  localparam int CLK_PERIOD = 20;   // 50 MHz
  // Expected cycle counts, rounded up by hand from the chosen durations
  localparam int PAUSE = 100;       // 2 us * 50
  localparam int REFI  = 100;       // 2000 ns at 20 ns
  localparam int CSR   = 1;         // 10 ns
  localparam int CHR   = 1;         // 15 ns
  localparam int RASL  = 3;         // 50 ns
  localparam int RP    = 3;         // 50 ns
  localparam int WARM  = 8;
  localparam int PERIOD = 1 + CSR + RASL + RP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, ready, overdue, bus_own, ras_n, cas_n, we_n;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_refresh_sched #(
    .CLK_MHZ(50), .PAUSE_US(2), .REFI_NS(2000), .TRAS_NS(50), .TRP_NS(50),
    .TCSR_NS(10), .TCHR_NS(15), .WARM_CYC(8), .MAX_PEND(2), .PEND_W(4)
  ) i_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ready(ready), .overdue(overdue), .bus_own(bus_own),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  // Port monitor, sampled on the falling edge
  int cyc = 0, since_rst = 0, first_cas = -1, rdy_rise_sr = -1;
  int ras_falls = 0, cas_fall_at = 0, ras_fall_at = 0, ras_rise_at = 0, last_gap = 0;
  int ready_rise_at = 0, req_rise_at = 0;
  int shape_bad = 0, we_bad = 0, own_bad = 0;
  bit pr = 1, pc = 1, po = 0, prdy = 0, preq = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      since_rst = 0; first_cas = -1; ras_falls = 0; rdy_rise_sr = -1;
      pr = 1; pc = 1; po = 0; prdy = 0; preq = 0;
    end else begin
      since_rst++;
      if (pc && !cas_n) begin
        cas_fall_at = cyc;
        if (first_cas < 0) first_cas = since_rst;
      end
      if (!pc && cas_n && (cyc - cas_fall_at != CSR + CHR)) shape_bad++;
      if (pr && !ras_n) begin
        ras_falls++;
        if (cas_n || (cyc - cas_fall_at != CSR)) shape_bad++;
        last_gap = cyc - ras_fall_at;
        ras_fall_at = cyc;
      end
      if (!pr && ras_n) begin
        if (cyc - ras_fall_at != RASL) shape_bad++;
        ras_rise_at = cyc;
      end
      if (po && !bus_own && (cyc - ras_rise_at != RP)) shape_bad++;
      if (!we_n) we_bad++;
      if ((!ras_n || !cas_n) && !bus_own) own_bad++;
      if (!prdy && ready) begin ready_rise_at = cyc; rdy_rise_sr = since_rst; end
      if (!preq && ref_req) req_rise_at = cyc;
      pr = ras_n; pc = cas_n; po = bus_own; prdy = ready; preq = ref_req;
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_ready(input int lim);
    for (int i = 0; i < lim && !ready; i++) step(1);
  endtask

  task automatic wait_req(input int lim);
    for (int i = 0; i < lim && !ref_req; i++) step(1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; ref_gnt = 1'b0;
    step(3);
    chk("R1", "ras_n in reset", ras_n, 1);
    chk("R1", "cas_n in reset", cas_n, 1);
    chk("R1", "we_n in reset", we_n, 1);
    chk("R1", "bus_own in reset", bus_own, 0);
    chk("R1", "ready in reset", ready, 0);
    chk("R1", "ref_req in reset", ref_req, 0);
    chk("R1", "overdue in reset", overdue, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_init;
    wait_ready(2000);
    chk("R2", "first CAS fall after release", first_cas, PAUSE + 1);
    chk("R3", "warm-up RAS falls", ras_falls, WARM);
    chk("R3", "ready rise cycle", rdy_rise_sr, PAUSE + WARM * PERIOD);
    chk("R4", "strobe shape errors", shape_bad, 0);
    chk("R5", "we_n low samples", we_bad, 0);
    chk("R5", "strobe without bus_own", own_bad, 0);
    chk("R6", "no request at ready", ref_req, 0);
    step(5);
    chk("R3", "ready stays high", ready, 1);
  endtask

  task automatic t_interval;
    ref_gnt = 1'b0;
    wait_req(300);
    chk("R6", "request delay after ready", req_rise_at - ready_rise_at, REFI);
    chk("R9", "no overdue at debt 1", overdue, 0);
    step(3);
    chk("R6", "request held without grant", ref_req, 1);
  endtask

  task automatic t_grant;
    int base;
    int g;
    base = ras_falls;
    ref_gnt = 1'b1;
    g = cyc;
    step(1);
    chk("R7", "CAS low one cycle after grant", cas_n, 0);
    chk("R7", "CAS fall cycle", cas_fall_at - g, 1);
    for (int i = 0; i < 20 && bus_own; i++) step(1);
    ref_gnt = 1'b0;
    step(2);
    chk("R7", "one refresh per debt unit", ras_falls - base, 1);
    chk("R7", "request cleared after refresh", ref_req, 0);
    chk("R4", "shape errors after grant", shape_bad, 0);
  endtask

  task automatic t_ignore;
    int base;
    base = ras_falls;
    ref_gnt = 1'b1;
    step(20);
    chk("R7", "grant without request, RAS falls", ras_falls - base, 0);
    chk("R7", "grant without request, bus_own", bus_own, 0);
    ref_gnt = 1'b0;
  endtask

  task automatic t_debt;
    int base;
    wait_req(300);
    chk("R9", "overdue at debt 1", overdue, 0);
    step(REFI + 2);
    chk("R9", "overdue at debt 2", overdue, 0);
    chk("R6", "request at debt 2", ref_req, 1);
    step(REFI);
    chk("R9", "overdue at debt 3", overdue, 1);
    base = ras_falls;
    ref_gnt = 1'b1;
    for (int i = 0; i < 100 && (ref_req || bus_own); i++) step(1);
    ref_gnt = 1'b0;
    chk("R8", "refreshes in drain burst", ras_falls - base, 3);
    chk("R8", "RAS fall spacing in burst", last_gap, PERIOD);
    chk("R9", "overdue after drain", overdue, 0);
    chk("R8", "request low after drain", ref_req, 0);
  endtask

  task automatic t_rereset;
    ref_gnt = 1'b1;
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    wait_ready(2000);
    chk("R7", "grant before ready, first CAS fall", first_cas, PAUSE + 1);
    chk("R7", "grant before ready, warm-up count", ras_falls, WARM);
    ref_gnt = 1'b0;
    step(2);
    chk("R5", "we_n low samples overall", we_bad, 0);
  endtask

  initial begin
    step(1);
    t_reset();
    t_init();
    t_interval();
    t_grant();
    t_ignore();
    t_debt();
    t_rereset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R3 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule